// File: doc/BRIEF.md
# Phase-Disposition Multicarrier PWM Gate Generator

The block makes the ten gate commands for a fifteen-level inverter. The inverter has an H-bridge and a stacked pair of sources in a 1:3 ratio. Fourteen triangular carriers share one frequency and one phase. Each carrier sits in its own amplitude band, and every carrier is compared with one signed reference sample. The number of carriers that the reference exceeds is the output level, from 0 to 14. That level is decoded into fifteen exclusive pulses, and fixed XOR/NOT networks combine the pulses into the switch commands.

All carriers come from one up/down counter whose peak is set by an input. Band k is that counter plus k times the peak. The signed reference is shifted by seven bands into an unsigned scale that covers all fourteen bands. A reference outside that scale saturates. The comparator outputs are registered, and so are the gate outputs.

Top module: `pd_gate_gen`

## Requirements
- R1: The carrier counter starts at 0 counting up. It changes by exactly one every cycle. It turns down when it reaches the effective peak and turns up when it reaches 0. The effective peak is `car_peak`, or 1 when `car_peak` is 0.
- R2: Carrier k (k = 0..13) equals counter + k·peak. Comparator k is high when u > carrier k, where u = `ref_in` + 7·peak.
- R3: The level is the number of high comparators (0..14). Pulse Ck is high exactly when the level equals k, so exactly one pulse is high at a time.
- R4: `sw1` is high for levels 0–5, and `sw2` is its complement.
- R5: `sw4` is high for levels 0–8, and `sw3` is its complement.
- R6: `sw7` is high for levels 2, 5, 7, 8, 12 and 14, and `sw8` is its complement.
- R7: `sw5` is high for levels 1, 4, 7, 10, 11, 12 and 13, and `sw6` is its complement.
- R8: `sw_stk` is high for levels 0, 1, 2, 12, 13 and 14. `sw_byp` is high for levels 3, 4, 5, 9, 10 and 11. The two are never high together.
- R9: The reference and counter values present at clock edge e determine the gate outputs that appear after edge e+1.
- R10: While reset is low, the counter is 0 and counting up, and the gates hold their level-0 values: sw1, sw4, sw6, sw8 and sw_stk high, the others low.
- R11: u saturates to 0 when `ref_in` + 7·peak < 0, and to 14·peak when it exceeds 14·peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | CW+5 | Signed reference sample, nominal range ±7·peak |
| car_peak | input | CW | Carrier peak count; sets the carrier period |
| sw1 | output | 1 | H-bridge switch 1 |
| sw2 | output | 1 | H-bridge switch 2 |
| sw3 | output | 1 | H-bridge switch 3 |
| sw4 | output | 1 | H-bridge switch 4 |
| sw5 | output | 1 | Switch 5 |
| sw6 | output | 1 | Switch 6 |
| sw7 | output | 1 | Switch 7 |
| sw8 | output | 1 | Switch 8 |
| sw_stk | output | 1 | Series switch that stacks the upper source |
| sw_byp | output | 1 | Bypass switch of the lower source |

## Verification
The gate outputs are due two clock edges after the reference and counter values that produce them. The first edge registers the comparators and the second registers the gates. The bench changes the reference at the falling edge and computes the expected level from that reference and from its own model of the counter at that moment. It holds the result in a two-stage delay line and compares it against the ports at the falling edge two cycles later. During reset, the outputs are compared directly against the level-0 pattern.

// File: rtl/pdpwm_pkg.sv
package pdpwm_pkg;
  localparam int NCAR = 14;
  localparam int NLVL = NCAR + 1;

  typedef struct packed {
    logic s1, s2, s3, s4, s5, s6, s7, s8, stk, byp;
  } gate_t;

  function automatic logic [3:0] count_high(input logic [NCAR-1:0] v);
    logic [3:0] n;
    n = 4'd0;
    for (int i = 0; i < NCAR; i++) n = n + {3'd0, v[i]};
    return n;
  endfunction

  function automatic gate_t gates_of(input logic [NLVL-1:0] c);
    gate_t g;
    g.s1  = c[0] ^ c[1] ^ c[2] ^ c[3] ^ c[4] ^ c[5];
    g.s2  = ~g.s1;
    g.s4  = g.s1 ^ c[6] ^ c[7] ^ c[8];
    g.s3  = ~g.s4;
    g.s7  = c[2] ^ c[5] ^ c[7] ^ c[8] ^ c[12] ^ c[14];
    g.s8  = ~g.s7;
    g.s5  = g.s8 ^ c[0] ^ c[3] ^ c[6] ^ c[7] ^ c[9] ^ c[12];
    g.s6  = ~g.s5;
    g.stk = c[0] ^ c[1] ^ c[2] ^ c[12] ^ c[13] ^ c[14];
    g.byp = g.s1 ^ c[0] ^ c[1] ^ c[2] ^ c[9] ^ c[10] ^ c[11];
    return g;
  endfunction
endpackage

// File: rtl/pdpwm_tri_counter.sv
module pdpwm_tri_counter #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] peak,
  output logic [CW-1:0] cnt
);
  logic going_up;
  logic past_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      going_up <= 1'b1;
    end else if (going_up) begin
      if (cnt >= peak) begin
        going_up <= 1'b0;
        cnt      <= cnt - 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (cnt == '0) begin
        going_up <= 1'b1;
        cnt      <= cnt + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1))); // R1
endmodule

// File: rtl/pdpwm_compare.sv
module pdpwm_compare #(
  parameter int CW   = 6,
  parameter int NCAR = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic signed [CW+4:0] ref_in,
  input  logic [CW-1:0]     peak,
  input  logic [CW-1:0]     cnt,
  output logic [NCAR-1:0]   cmp_q
);
  localparam int RW = CW + 5;
  localparam int UW = CW + 4;
  localparam int SW = RW + 1;

  logic [UW-1:0]        half, span, u_ref;
  logic signed [SW-1:0] shifted, span_s;

  assign half    = UW'(peak) * UW'(NCAR / 2);
  assign span    = UW'(peak) * UW'(NCAR);
  assign span_s  = $signed({{(SW-UW){1'b0}}, span});
  assign shifted = $signed({ref_in[RW-1], ref_in}) + $signed({{(SW-UW){1'b0}}, half});

  always_comb begin
    if (shifted < 0)           u_ref = '0;
    else if (shifted > span_s) u_ref = span;
    else                       u_ref = shifted[UW-1:0];
  end

  for (genvar k = 0; k < NCAR; k++) begin : g_band
    logic [UW-1:0] carrier;
    assign carrier = UW'(cnt) + UW'(k) * UW'(peak);
    always_ff @(posedge clk) begin
      if (!rst_n) cmp_q[k] <= 1'b0;
      else        cmp_q[k] <= (u_ref > carrier);
    end
    if (k > 0) begin : g_therm
      AST_THERMOMETER: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_q[k] |-> cmp_q[k-1]); // R2
    end
  end
endmodule

// File: rtl/pdpwm_level_decode.sv
module pdpwm_level_decode #(
  parameter int NCAR = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCAR-1:0]  cmp_q,
  output logic [3:0]       level,
  output logic [NCAR:0]    pulse
);
  import pdpwm_pkg::*;

  assign level = count_high(cmp_q);

  for (genvar k = 0; k <= NCAR; k++) begin : g_pulse
    assign pulse[k] = (level == 4'(k));
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pulse) == 1); // R3
endmodule

// File: rtl/pdpwm_gate_logic.sv
module pdpwm_gate_logic #(
  parameter int NCAR = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCAR:0]         pulse,
  output pdpwm_pkg::gate_t      gate_q
);
  import pdpwm_pkg::*;

  localparam logic [NCAR:0] LVL0 = (NCAR+1)'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= gates_of(LVL0);
    else        gate_q <= gates_of(pulse);
  end

  AST_S1_IN_S4: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q.s1 |-> gate_q.s4); // R5
  AST_STK_BYP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_q.stk && gate_q.byp)); // R8
endmodule

// File: rtl/pd_gate_gen.sv
module pd_gate_gen #(
  parameter int CW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [CW+4:0] ref_in,
  input  logic [CW-1:0]        car_peak,
  output logic                 sw1,
  output logic                 sw2,
  output logic                 sw3,
  output logic                 sw4,
  output logic                 sw5,
  output logic                 sw6,
  output logic                 sw7,
  output logic                 sw8,
  output logic                 sw_stk,
  output logic                 sw_byp
);
  import pdpwm_pkg::*;

  logic [CW-1:0]   peak_eff;
  logic [CW-1:0]   cnt;
  logic [NCAR-1:0] cmp_q;
  logic [3:0]      level;
  logic [NCAR:0]   pulse;
  gate_t           gate_q;

  assign peak_eff = (car_peak == '0) ? CW'(1) : car_peak;

  pdpwm_tri_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .peak(peak_eff), .cnt(cnt)
  );

  pdpwm_compare #(.CW(CW), .NCAR(NCAR)) u_cmp (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .peak(peak_eff),
    .cnt(cnt), .cmp_q(cmp_q)
  );

  pdpwm_level_decode #(.NCAR(NCAR)) u_dec (
    .clk(clk), .rst_n(rst_n), .cmp_q(cmp_q), .level(level), .pulse(pulse)
  );

  pdpwm_gate_logic #(.NCAR(NCAR)) u_gate (
    .clk(clk), .rst_n(rst_n), .pulse(pulse), .gate_q(gate_q)
  );

  assign sw1    = gate_q.s1;
  assign sw2    = gate_q.s2;
  assign sw3    = gate_q.s3;
  assign sw4    = gate_q.s4;
  assign sw5    = gate_q.s5;
  assign sw6    = gate_q.s6;
  assign sw7    = gate_q.s7;
  assign sw8    = gate_q.s8;
  assign sw_stk = gate_q.stk;
  assign sw_byp = gate_q.byp;

  AST_PEAK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= peak_eff || $past(car_peak) != car_peak); // R1
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    level <= 4'd14); // R3
endmodule

// File: tb/pd_gate_gen_bench.sv
`timescale 1ns/1ps
module pd_gate_gen_bench;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [CW+4:0] ref_in = '0;
  logic [CW-1:0] car_peak = CW'(3);
  logic sw1, sw2, sw3, sw4, sw5, sw6, sw7, sw8, sw_stk, sw_byp;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pd_gate_gen #(.CW(CW)) u_pd_gate_gen (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .car_peak(car_peak),
    .sw1(sw1), .sw2(sw2), .sw3(sw3), .sw4(sw4), .sw5(sw5), .sw6(sw6),
    .sw7(sw7), .sw8(sw8), .sw_stk(sw_stk), .sw_byp(sw_byp)
  );

  // Level sets as 15-bit masks, bit L = level L (R4..R8)
  localparam logic [14:0] M_S1  = 15'h003F;
  localparam logic [14:0] M_S4  = 15'h01FF;
  localparam logic [14:0] M_S7  = 15'h51A4;
  localparam logic [14:0] M_S5  = 15'h3C92;
  localparam logic [14:0] M_STK = 15'h7007;
  localparam logic [14:0] M_BYP = 15'h0E38;

  // order: sw1..sw8, stk, byp
  function automatic logic [9:0] vec_of(input int lv);
    return {M_S1[lv], ~M_S1[lv], ~M_S4[lv], M_S4[lv], M_S5[lv], ~M_S5[lv],
            M_S7[lv], ~M_S7[lv], M_STK[lv], M_BYP[lv]};
  endfunction

  // R2 R3 R11: level from clamped reference and counter, arithmetically
  function automatic int level_of(input int r, input int c, input int pe);
    int u, l;
    u = r + 7 * pe;
    if (u < 0) u = 0;
    if (u > 14 * pe) u = 14 * pe;
    if (u <= c) return 0;
    l = (u - c + pe - 1) / pe;
    return (l > 14) ? 14 : l;
  endfunction

  function automatic string tag_of(input logic [9:0] d);
    if (d[9:8] != 0) return "R4";
    if (d[7:6] != 0) return "R5";
    if (d[3:2] != 0) return "R6";
    if (d[5:4] != 0) return "R7";
    return "R8";
  endfunction

  function automatic logic [9:0] dut_vec();
    return {sw1, sw2, sw3, sw4, sw5, sw6, sw7, sw8, sw_stk, sw_byp};
  endfunction

  task automatic check(input logic [9:0] exp, input string tag, input int info);
    logic [9:0] act;
    act = dut_vec();
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s (t=%0t info=%0d): actual %b expected %b", tag, $time, info, act, exp);
    end
  endtask

  task automatic run_cfg(input int pk, input int ncyc);
    int pe, mcnt, r, rdir;
    bit up;
    logic [9:0] d1, d2;
    pe = (pk == 0) ? 1 : pk;   // R1: peak 0 acts as 1
    @(negedge clk);
    rst_n = 1'b0;
    car_peak = CW'(pk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(vec_of(0), "R10", pk);   // R10 reset state
    end
    rst_n = 1'b1;
    mcnt = 0; up = 1'b1;
    r = -8 * pe; rdir = 1;
    d1 = '0; d2 = '0;
    for (int i = 0; i < ncyc; i++) begin
      if (i >= 2) check(d2, tag_of(d2 ^ dut_vec()), level_of(r, mcnt, pe)); // R9 two-edge latency
      d2 = d1;
      ref_in = (CW+5)'(r);
      d1 = vec_of(level_of(r, mcnt, pe));
      // R1 counter model
      if (up) begin
        if (mcnt >= pe) begin up = 1'b0; mcnt = mcnt - 1; end
        else mcnt = mcnt + 1;
      end else begin
        if (mcnt == 0) begin up = 1'b1; mcnt = 1; end
        else mcnt = mcnt - 1;
      end
      // reference sweep beyond both saturation points (R11)
      r = r + rdir;
      if (r >= 8 * pe) rdir = -1;
      if (r <= -8 * pe) rdir = 1;
      @(negedge clk);
    end
  endtask

  initial begin
    run_cfg(3, 700);
    run_cfg(1, 300);
    run_cfg(5, 900);
    run_cfg(0, 300);
    run_cfg(2, 500);
    run_cfg(63, 2400);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule